// File: doc/BRIEF.md
# Two-Wire Serial Byte Shifter with Slave Address Match

This block is the byte layer of a two-wire serial controller. An external bit engine handles start and stop detection, clock stretching, acknowledge and arbitration. For each clock bit it hands this block one strobe and the sampled data-line value. The block keeps one data byte, which is also the transmit byte. On every accepted strobe the most significant bit leaves the byte towards the data-line driver, and the sampled line value enters at the bottom.

Because the byte shifts in while it shifts out, it always ends up holding the byte that actually appeared on the wire. A master that loses arbitration partway through a byte can therefore carry on as a slave receiver with no reload.

After the eighth bit the block raises a serial-interrupt flag and gives a one-cycle byte-complete pulse. While the flag is up the CPU may read and rewrite the byte. When the engine marks the byte as an address byte and the block is in slave mode, the block compares the received address with its own address register. That register also holds a general-call enable bit.

Top module: `smb_byte_shifter`

## Requirements
- R1: After reset the data register, the address register, the interrupt flag, the byte-complete pulse, the address-match flag, the direction bit and the line drive bit are all 0.
- R2: The line drive bit `sda_out` always equals bit 7 of the data register, so a written byte leaves most-significant bit first, one bit per accepted strobe.
- R3: Each accepted strobe shifts the data register left by one and inserts `bit_in` at bit 0. After eight strobes the register equals the eight sampled bits, with the first sampled bit in bit 7.
- R4: When the driven bits differ from the sampled bus bits, the register ends up holding the bus byte. Changing `master_mode` afterwards leaves it unchanged.
- R5: The eighth accepted strobe sets `si_flag` and raises `byte_done` for exactly one cycle, both on the same clock edge. `si_flag` stays set until `si_clr` is pulsed; a set and a clear in the same cycle leave it set.
- R6: A strobe is accepted only while `enable` is 1 and `si_flag` is 0. Otherwise the data register and the bit count do not change.
- R7: A CPU data write takes effect only while `si_flag` is 1 or `enable` is 0; otherwise it is ignored. `dat_rdata` shows the data register under that same condition and reads 0x00 otherwise. The address register is written on every `adr_wr`.
- R8: In slave mode, when an address byte completes (`addr_phase` high on the eighth strobe), bits 7..1 of the received byte are compared with address-register bits 7..1. Received bit 0 is not compared; it is loaded into `rw_bit`.
- R9: A received address of 0 in bits 7..1 matches only when address-register bit 0 (general-call enable) is 1. It never matches through the own-address compare.
- R10: While `master_mode` is 1 the address register has no effect. `addr_match` is 0 from the edge after `master_mode` is sampled high.
- R11: `addr_match` and `rw_bit` change only when an address byte completes or when master mode clears them. Data bytes leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Interface enable |
| master_mode | input | 1 | 1 = master, 0 = slave |
| bit_shift | input | 1 | One-cycle strobe from the bit engine: shift one bit |
| bit_in | input | 1 | Sampled data-line value for this strobe |
| addr_phase | input | 1 | Current byte is an address byte |
| si_clr | input | 1 | CPU strobe clearing the interrupt flag |
| dat_wr | input | 1 | CPU write strobe for the data register |
| adr_wr | input | 1 | CPU write strobe for the address register |
| cpu_wdata | input | 8 | CPU write data |
| dat_rdata | output | 8 | Data register read value (0 when not readable) |
| adr_rdata | output | 8 | Address register read value |
| sda_out | output | 1 | Bit to drive onto the data line |
| si_flag | output | 1 | Serial-interrupt flag |
| byte_done | output | 1 | One-cycle pulse at byte completion |
| addr_match | output | 1 | Node addressed as slave |
| rw_bit | output | 1 | Direction bit of the last address byte |

## Verification
Several rules are checked on every cycle: master mode clears the match flag, the byte-complete pulse lasts one cycle and coincides with the flag, the flag holds until cleared, the register freezes while a strobe is not allowed, writes are blocked while shifting, and the match flag is stable outside address-byte completion. The bench's sweeps are what show the arithmetic behaviour. These cover:
- every possible received address byte, with general call both on and off;
- many pairs of transmit byte and bus byte, which exercise the simultaneous shift and the arbitration-loss case;
- the exact bit order on the line;
- the read gating seen through the CPU ports.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int unsigned SMB_BYTE_W = 8;

  // address compare: rx and own are the 7 address bits, gc the enable
  function automatic logic smb_addr_hit(input logic [SMB_BYTE_W-2:0] rx,
                                        input logic [SMB_BYTE_W-2:0] own,
                                        input logic                  gc);
    logic zero;
    zero = (rx == '0);
    return zero ? gc : (rx == own);
  endfunction
endpackage

// File: rtl/smb_shift_reg.sv
module smb_shift_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next_shift
);
  assign q_next_shift = {q[W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load_en) begin
      q <= load_val;
    end else if (shift_en) begin
      q <= q_next_shift;
    end
  end
endmodule

// File: rtl/smb_bit_ctl.sv
module smb_bit_ctl #(
  parameter int unsigned W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cnt_clr,
  input  logic shift_en,
  input  logic si_clr,
  output logic last_bit,
  output logic si_flag,
  output logic byte_done
);
  localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  assign last_bit = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      si_flag   <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= shift_en && last_bit;
      if (cnt_clr) begin
        cnt <= '0;
      end else if (shift_en) begin
        cnt <= last_bit ? '0 : cnt + 1'b1;
      end
      if (shift_en && last_bit) begin
        si_flag <= 1'b1;
      end else if (si_clr) begin
        si_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/smb_addr_cmp.sv
module smb_addr_cmp #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         master,
  input  logic         eval,
  input  logic [W-1:0] rx_byte,
  input  logic [W-1:0] own_reg,
  output logic         match,
  output logic         rw
);
  import smb_pkg::*;

  logic hit;

  always_comb begin
    hit = (rx_byte[W-1:1] == '0) ? own_reg[0]
                                 : (rx_byte[W-1:1] == own_reg[W-1:1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match <= 1'b0;
      rw    <= 1'b0;
    end else if (master) begin
      match <= 1'b0;
    end else if (eval) begin
      match <= hit;
      rw    <= rx_byte[0];
    end
  end
endmodule

// File: rtl/smb_byte_shifter.sv
module smb_byte_shifter #(
  parameter int unsigned BYTE_W = smb_pkg::SMB_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              master_mode,
  input  logic              bit_shift,
  input  logic              bit_in,
  input  logic              addr_phase,
  input  logic              si_clr,
  input  logic              dat_wr,
  input  logic              adr_wr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] dat_rdata,
  output logic [BYTE_W-1:0] adr_rdata,
  output logic              sda_out,
  output logic              si_flag,
  output logic              byte_done,
  output logic              addr_match,
  output logic              rw_bit
);
  logic              shift_ok;
  logic              cpu_ok;
  logic              last_bit;
  logic [BYTE_W-1:0] dat_q;
  logic [BYTE_W-1:0] rx_next;
  logic [BYTE_W-1:0] adr_q;

  assign shift_ok = enable && !si_flag && bit_shift;
  assign cpu_ok   = si_flag || !enable;

  smb_shift_reg #(.W(BYTE_W)) u_sr (
    .clk          (clk),
    .rst          (rst),
    .shift_en     (shift_ok),
    .bit_in       (bit_in),
    .load_en      (dat_wr && cpu_ok),
    .load_val     (cpu_wdata),
    .q            (dat_q),
    .q_next_shift (rx_next)
  );

  smb_bit_ctl #(.W(BYTE_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .cnt_clr   (!enable),
    .shift_en  (shift_ok),
    .si_clr    (si_clr),
    .last_bit  (last_bit),
    .si_flag   (si_flag),
    .byte_done (byte_done)
  );

  smb_addr_cmp #(.W(BYTE_W)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .master  (master_mode),
    .eval    (shift_ok && last_bit && addr_phase),
    .rx_byte (rx_next),
    .own_reg (adr_q),
    .match   (addr_match),
    .rw      (rw_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      adr_q <= '0;
    end else if (adr_wr) begin
      adr_q <= cpu_wdata;
    end
  end

  assign dat_rdata = cpu_ok ? dat_q : '0;
  assign adr_rdata = adr_q;
  assign sda_out   = dat_q[BYTE_W-1];
endmodule

// File: rtl/smb_byte_shifter_chk.sv
module smb_byte_shifter_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              master_mode,
  input logic              bit_shift,
  input logic              addr_phase,
  input logic              si_clr,
  input logic              dat_wr,
  input logic              si_flag,
  input logic              byte_done,
  input logic              addr_match,
  input logic [BYTE_W-1:0] data
);
  AST_MASTER_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    master_mode |=> !addr_match); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done); // R5

  AST_DONE_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> si_flag); // R5

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (si_flag && !si_clr) |=> si_flag); // R5

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    ((si_flag || !enable) && !dat_wr) |=> $stable(data)); // R6

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (enable && !si_flag && !bit_shift) |=> $stable(data)); // R7

  AST_MATCH_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && !(bit_shift && addr_phase)) |=> $stable(addr_match)); // R11
endmodule

bind smb_byte_shifter smb_byte_shifter_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .master_mode (master_mode),
  .bit_shift   (bit_shift),
  .addr_phase  (addr_phase),
  .si_clr      (si_clr),
  .dat_wr      (dat_wr),
  .si_flag     (si_flag),
  .byte_done   (byte_done),
  .addr_match  (addr_match),
  .data        (dat_q)
);

// File: tb/sim_smb_byte_shifter.sv
module sim_smb_byte_shifter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       master_mode = 1'b0;
  logic       bit_shift = 1'b0;
  logic       bit_in = 1'b0;
  logic       addr_phase = 1'b0;
  logic       si_clr = 1'b0;
  logic       dat_wr = 1'b0;
  logic       adr_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] dat_rdata;
  logic [7:0] adr_rdata;
  logic       sda_out;
  logic       si_flag;
  logic       byte_done;
  logic       addr_match;
  logic       rw_bit;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_byte_shifter u0 (
    .clk(clk), .rst(rst), .enable(enable), .master_mode(master_mode),
    .bit_shift(bit_shift), .bit_in(bit_in), .addr_phase(addr_phase),
    .si_clr(si_clr), .dat_wr(dat_wr), .adr_wr(adr_wr), .cpu_wdata(cpu_wdata),
    .dat_rdata(dat_rdata), .adr_rdata(adr_rdata), .sda_out(sda_out),
    .si_flag(si_flag), .byte_done(byte_done), .addr_match(addr_match),
    .rw_bit(rw_bit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // write data byte while the flag is set (or enable low), then clear flag
  task automatic load_and_clear(input logic [7:0] v);
    dat_wr = 1'b1; cpu_wdata = v; si_clr = 1'b1;
    tick();
    dat_wr = 1'b0; si_clr = 1'b0;
  endtask

  // shift one byte; check line bits against tx when chk_tx
  task automatic shift_byte(input logic [7:0] bus, input logic [7:0] tx,
                            input bit chk_tx, input bit adr);
    addr_phase = adr;
    for (int i = 0; i < 8; i++) begin
      if (chk_tx) chk("R2 sda bit", {31'd0, sda_out}, {31'd0, tx[7-i]});
      bit_shift = 1'b1;
      bit_in = bus[7-i];
      tick();
    end
    bit_shift = 1'b0;
    addr_phase = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] own;
    logic       exp_m;
    @(negedge clk);
    tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 dat", {24'd0, dat_rdata}, 32'h0);
    chk("R1 adr", {24'd0, adr_rdata}, 32'h0);
    chk("R1 flags", {27'd0, sda_out, si_flag, byte_done, addr_match, rw_bit}, 32'h0);

    // R2 R3 R4 R5: transmit/receive sweep, master mode
    master_mode = 1'b1;
    dat_wr = 1'b1; cpu_wdata = 8'hA5; tick(); dat_wr = 1'b0; // enable low: accepted
    chk("R7 write while disabled", {24'd0, dat_rdata}, 32'hA5);
    enable = 1'b1;
    for (int t = 0; t < 64; t++) begin
      logic [7:0] tx;
      logic [7:0] bus;
      tx  = 8'(t * 37 + 5);
      bus = (t % 4 == 0) ? tx : 8'(tx ^ 8'(t * 11 + 1)); // R4 differing bus
      if (t != 0) load_and_clear(tx);
      else begin
        enable = 1'b0; dat_wr = 1'b1; cpu_wdata = tx; tick();
        dat_wr = 1'b0; enable = 1'b1;
      end
      shift_byte(bus, tx, 1'b1, 1'b0);
      chk("R5 done pulse", {31'd0, byte_done}, 32'h1);
      chk("R5 flag set", {31'd0, si_flag}, 32'h1);
      chk("R3 rx byte", {24'd0, dat_rdata}, {24'd0, bus});
      chk("R2 sda msb", {31'd0, sda_out}, {31'd0, bus[7]});
      tick();
      chk("R5 pulse ends", {31'd0, byte_done}, 32'h0);
      chk("R5 flag holds", {31'd0, si_flag}, 32'h1);
      if (t % 8 == 1) begin
        master_mode = 1'b0; tick();
        chk("R4 kept after lost arb", {24'd0, dat_rdata}, {24'd0, bus});
        master_mode = 1'b1;
      end
    end

    // R6: strobes ignored while flag set
    begin
      logic [7:0] keep;
      keep = dat_rdata;
      bit_shift = 1'b1; bit_in = ~keep[0];
      repeat (3) tick();
      bit_shift = 1'b0;
      chk("R6 stall flag", {24'd0, dat_rdata}, {24'd0, keep});
      chk("R6 flag", {31'd0, si_flag}, 32'h1);
      // R5 set+clear: flag cleared by si_clr
      si_clr = 1'b1; tick(); si_clr = 1'b0;
      chk("R5 cleared", {31'd0, si_flag}, 32'h0);
      chk("R7 read gated", {24'd0, dat_rdata}, 32'h0);
      // R7: write ignored when enabled and flag clear
      dat_wr = 1'b1; cpu_wdata = ~keep; tick(); dat_wr = 1'b0;
      enable = 1'b0; tick();
      chk("R7 write ignored", {24'd0, dat_rdata}, {24'd0, keep});
      // R6: strobes ignored while disabled
      bit_shift = 1'b1; bit_in = ~keep[0]; repeat (2) tick(); bit_shift = 1'b0;
      chk("R6 stall disabled", {24'd0, dat_rdata}, {24'd0, keep});
      enable = 1'b1;
    end

    // R8 R9: slave address sweep, general call off then on
    master_mode = 1'b0;
    for (int g = 0; g < 2; g++) begin
      own = {7'h2A, 1'(g)};
      adr_wr = 1'b1; cpu_wdata = own; tick(); adr_wr = 1'b0;
      chk("R7 adr write", {24'd0, adr_rdata}, {24'd0, own});
      for (int a = 0; a < 256; a++) begin
        logic [7:0] rx;
        rx = 8'(a);
        shift_byte(rx, 8'h00, 1'b0, 1'b1);
        exp_m = (rx[7:1] == 7'd0) ? own[0] : (rx[7:1] == own[7:1]);
        chk(rx[7:1] == 7'd0 ? "R9 general call" : "R8 addr match",
            {31'd0, addr_match}, {31'd0, exp_m});
        chk("R8 rw bit", {31'd0, rw_bit}, {31'd0, rx[0]});
        si_clr = 1'b1; tick(); si_clr = 1'b0;
      end
    end

    // R11: match held across data byte
    shift_byte(8'h55, 8'h00, 1'b0, 1'b1);
    chk("R8 own hit", {31'd0, addr_match}, 32'h1);
    si_clr = 1'b1; tick(); si_clr = 1'b0;
    shift_byte(8'h00, 8'h00, 1'b0, 1'b0);
    chk("R11 hold match", {31'd0, addr_match}, 32'h1);
    chk("R11 hold rw", {31'd0, rw_bit}, 32'h1);
    si_clr = 1'b1; tick(); si_clr = 1'b0;

    // R10: master mode clears and blocks matching
    master_mode = 1'b1; tick();
    chk("R10 cleared", {31'd0, addr_match}, 32'h0);
    shift_byte(8'h54, 8'h00, 1'b0, 1'b1);
    chk("R10 no match in master", {31'd0, addr_match}, 32'h0);

    // R1: reset again returns registers to zero
    rst = 1'b1; tick(); rst = 1'b0; enable = 1'b0; tick();
    chk("R1 dat after reset", {24'd0, dat_rdata}, 32'h0);
    chk("R1 adr after reset", {24'd0, adr_rdata}, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule